// File: doc/BRIEF.md
# Keypad Sense and Tone Selection

This block sits between a four-by-four telephone keypad and a dual-tone generator. It watches four row lines and four column lines. Each line is pulled high when idle and is pressed by driving it low. From the pattern of pressed lines it decides four things: whether the handset audio should be muted, whether the tone oscillator should run, and which low-group (row) tone and which high-group (column) tone to play.

A clean key press is one row together with one column, and it enables both tones. A control input selects what happens with multiple closures. With that input low, anything other than a clean press plays no tone. With it high, a group that has exactly one pressed line may still sound on its own, but only when the other group has two or more pressed lines. A separate active-high tone enable silences both tones and stops the oscillator without affecting the mute indication.

All inputs are asynchronous. Every input passes through a two-flop synchroniser, and the decoded outputs are registered. An input held steady before clock edge n therefore shows at the outputs just after edge n+2. The reset input asserts asynchronously and is released through its own synchroniser.

Top module: `keypad_tone_select`

## Requirements
- R1: While reset is asserted, mute, osc_run, low_en and high_en are 0 and both indices are 0, whatever the key inputs are.
- R2: mute is 1 when any row_n or col_n bit is low and 0 when all eight are high, independent of allow_single and tone_enable.
- R3: With tone_enable high, exactly one row_n bit i low and exactly one col_n bit j low give low_en=1 with low_idx=i and high_en=1 with high_idx=j (bit 0 maps to index 0, up to bit 3 mapping to index 3).
- R4: With tone_enable low, low_en, high_en and osc_run are 0 for every key pattern.
- R5: With allow_single low, any pattern other than exactly one row plus exactly one column gives low_en=0 and high_en=0.
- R6: With allow_single high and tone_enable high, two or more rows low with exactly one column j low give high_en=1, high_idx=j and low_en=0.
- R7: With allow_single high and tone_enable high, exactly one row i low with two or more columns low give low_en=1, low_idx=i and high_en=0.
- R8: With allow_single high, two or more rows with two or more columns, or any pattern where one group has no line low, give low_en=0 and high_en=0.
- R9: osc_run is 1 exactly when at least one tone enable is 1, so column-only or row-only activity leaves it 0.
- R10: low_idx is 0 whenever low_en is 0, and high_idx is 0 whenever high_en is 0.
- R11: Inputs held steady before clock edge n are reflected at the outputs after edge n+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| row_n | input | 4 | Row lines, active low, bit i is row i+1 |
| col_n | input | 4 | Column lines, active low, bit j is column j+1 |
| allow_single | input | 1 | High lets a single-group tone through on multiple closures |
| tone_enable | input | 1 | Low silences both tones and stops the oscillator |
| mute | output | 1 | High while any key line is active |
| osc_run | output | 1 | Oscillator run enable |
| low_en | output | 1 | Low-group (row) tone enable |
| low_idx | output | 2 | Row index of the low-group tone |
| high_en | output | 1 | High-group (column) tone enable |
| high_idx | output | 2 | Column index of the high-group tone |

## Verification
The assertions compare the outputs with the synchronised inputs from one cycle earlier. They therefore assume that metastability is resolved inside the synchroniser, and that each input is seen at a single clock edge. The stimulus changes inputs only on the falling clock edge. It holds every pattern for several cycles, so each pattern passes through both synchroniser stages as one clean value. During reset the keys are held in a pressed pattern. They return to idle before reset is released, so no pressed state is left in the pipeline.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int ROWS_DEF  = 4;
  localparam int COLS_DEF  = 4;
  localparam int STAGES_DEF = 2;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_ONE  = 2'd1,
    GRP_MANY = 2'd2
  } grp_cls_e;
endpackage

// File: rtl/kp_rst_sync.sv
module kp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/kp_group.sv
module kp_group
  import kp_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  act,
  output grp_cls_e      cls,
  output logic [IW-1:0] idx
);
  logic [CW-1:0] cnt;
  logic [IW-1:0] part [N];

  for (genvar g = 0; g < N; g++) begin : g_line
    assign part[g] = act[g] ? IW'(g) : '0;
  end

  always_comb begin
    cnt = '0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(act[i]);
      idx = idx | part[i];
    end
    if (cnt == CW'(0))      cls = GRP_NONE;
    else if (cnt == CW'(1)) cls = GRP_ONE;
    else                    cls = GRP_MANY;
  end
endmodule

// File: rtl/keypad_tone_select.sv
module keypad_tone_select
  import kp_pkg::*;
#(
  parameter int ROWS   = ROWS_DEF,
  parameter int COLS   = COLS_DEF,
  parameter int STAGES = STAGES_DEF,
  localparam int RIW = $clog2(ROWS),
  localparam int CIW = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] row_n,
  input  logic [COLS-1:0] col_n,
  input  logic            allow_single,
  input  logic            tone_enable,
  output logic            mute,
  output logic            osc_run,
  output logic            low_en,
  output logic [RIW-1:0]  low_idx,
  output logic            high_en,
  output logic [CIW-1:0]  high_idx
);
  localparam int KW = ROWS + COLS;

  logic            rst_sync_n;
  logic [KW-1:0]   keys_s;
  logic [1:0]      ctrl_s;
  logic [ROWS-1:0] row_act;
  logic [COLS-1:0] col_act;
  logic            allow_s;
  logic            tone_s;
  grp_cls_e        row_cls, col_cls;
  logic [RIW-1:0]  row_code;
  logic [CIW-1:0]  col_code;

  logic            mute_nx, osc_nx, low_nx, high_nx;
  logic [RIW-1:0]  low_idx_nx;
  logic [CIW-1:0]  high_idx_nx;

  kp_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  kp_sync #(.W(KW), .STAGES(STAGES), .RST_VAL({KW{1'b1}})) u_keys (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({col_n, row_n}),
    .q     (keys_s)
  );

  kp_sync #(.W(2), .STAGES(STAGES), .RST_VAL(2'b01)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({allow_single, tone_enable}),
    .q     (ctrl_s)
  );

  assign row_act = ~keys_s[ROWS-1:0];
  assign col_act = ~keys_s[KW-1:ROWS];
  assign tone_s  = ctrl_s[0];
  assign allow_s = ctrl_s[1];

  kp_group #(.N(ROWS)) u_rows (
    .act (row_act),
    .cls (row_cls),
    .idx (row_code)
  );

  kp_group #(.N(COLS)) u_cols (
    .act (col_act),
    .cls (col_cls),
    .idx (col_code)
  );

  always_comb begin
    mute_nx = (|row_act) | (|col_act);
    low_nx  = tone_s && (row_cls == GRP_ONE) &&
              ((col_cls == GRP_ONE) || (allow_s && (col_cls == GRP_MANY)));
    high_nx = tone_s && (col_cls == GRP_ONE) &&
              ((row_cls == GRP_ONE) || (allow_s && (row_cls == GRP_MANY)));
    osc_nx      = low_nx | high_nx;
    low_idx_nx  = low_nx  ? row_code : '0;
    high_idx_nx = high_nx ? col_code : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mute     <= 1'b0;
      osc_run  <= 1'b0;
      low_en   <= 1'b0;
      low_idx  <= '0;
      high_en  <= 1'b0;
      high_idx <= '0;
    end else begin
      mute     <= mute_nx;
      osc_run  <= osc_nx;
      low_en   <= low_nx;
      low_idx  <= low_idx_nx;
      high_en  <= high_nx;
      high_idx <= high_idx_nx;
    end
  end
endmodule

// File: rtl/kp_checker.sv
module kp_checker #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RIW = $clog2(ROWS),
  localparam int CIW = $clog2(COLS)
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic [ROWS-1:0] row_act,
  input logic [COLS-1:0] col_act,
  input logic            allow_s,
  input logic            tone_s,
  input logic            mute,
  input logic            osc_run,
  input logic            low_en,
  input logic [RIW-1:0]  low_idx,
  input logic            high_en,
  input logic [CIW-1:0]  high_idx
);
  // R2
  mute_track_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mute == $past((|row_act) || (|col_act)));

  // R4
  tone_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(!tone_s) |-> (!low_en && !high_en && !osc_run));

  // R3
  clean_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(tone_s && ($countones(row_act) == 1) && ($countones(col_act) == 1))
    |-> (low_en && high_en && osc_run));

  // R5
  strict_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(!allow_s && !(($countones(row_act) == 1) && ($countones(col_act) == 1)))
    |-> (!low_en && !high_en));

  // R6
  high_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(tone_s && allow_s && ($countones(row_act) > 1) && ($countones(col_act) == 1))
    |-> (high_en && !low_en));

  // R7
  low_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(tone_s && allow_s && ($countones(row_act) == 1) && ($countones(col_act) > 1))
    |-> (low_en && !high_en));

  // R9
  osc_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!low_en && !high_en) |-> !osc_run);

  // R10
  low_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !low_en |-> (low_idx == '0));

  // R10
  high_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !high_en |-> (high_idx == '0));
endmodule

bind keypad_tone_select kp_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .row_act    (row_act),
  .col_act    (col_act),
  .allow_s    (allow_s),
  .tone_s     (tone_s),
  .mute       (mute),
  .osc_run    (osc_run),
  .low_en     (low_en),
  .low_idx    (low_idx),
  .high_en    (high_en),
  .high_idx   (high_idx)
);

// File: tb/keypad_tone_select_test.sv
`timescale 1ns/1ps
module keypad_tone_select_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] row_n, col_n;
  logic       allow_single, tone_enable;
  logic       mute, osc_run, low_en, high_en;
  logic [1:0] low_idx, high_idx;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit check_on = 1'b0;
  bit done = 1'b0;
  logic [9:0] hist[$];

  always #2 clk = ~clk;

  keypad_tone_select uut (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
    .allow_single(allow_single), .tone_enable(tone_enable),
    .mute(mute), .osc_run(osc_run), .low_en(low_en), .low_idx(low_idx),
    .high_en(high_en), .high_idx(high_idx)
  );

  function automatic int ones(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic int first(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic string tag_of(input logic [9:0] s);
    int r = ones(~s[3:0]);
    int c = ones(~s[7:4]);
    if (!s[9]) return "R4";
    if (r == 1 && c == 1) return "R3";
    if (!s[8]) return "R5";
    if (r > 1 && c == 1) return "R6";
    if (r == 1 && c > 1) return "R7";
    return "R8";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model compared on every falling edge
  always @(posedge clk) begin
    hist.push_back({tone_enable, allow_single, col_n, row_n});
    if (hist.size() > 3) void'(hist.pop_front());
  end

  always @(negedge clk) begin
    if (check_on && !done) begin
      logic [9:0] s;
      logic [3:0] ra, ca;
      int r, c, e_low, e_high, e_mute, e_osc, e_li, e_hi;
      string t;
      s = hist[0];
      ra = ~s[3:0];
      ca = ~s[7:4];
      r = ones(ra);
      c = ones(ca);
      e_mute = (r + c > 0) ? 1 : 0;
      e_low = (s[9] && r == 1 && (c == 1 || (s[8] && c > 1))) ? 1 : 0;
      e_high = (s[9] && c == 1 && (r == 1 || (s[8] && r > 1))) ? 1 : 0;
      e_osc = (e_low || e_high) ? 1 : 0;
      e_li = e_low ? first(ra) : 0;
      e_hi = e_high ? first(ca) : 0;
      t = tag_of(s);
      check("R2", "mute", int'(mute), e_mute);
      check(t, "low_en", int'(low_en), e_low);
      check(t, "high_en", int'(high_en), e_high);
      check("R9", "osc_run", int'(osc_run), e_osc);
      check(e_low ? "R3" : "R10", "low_idx", int'(low_idx), e_li);
      check(e_high ? "R3" : "R10", "high_idx", int'(high_idx), e_hi);
    end
  end

  task automatic apply(input logic [3:0] r, input logic [3:0] c,
                       input logic a, input logic t, input int n);
    @(negedge clk);
    row_n = r; col_n = c; allow_single = a; tone_enable = t;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) hist.push_back(10'h2FF);
    rst_n = 1'b0;
    row_n = 4'b1110; col_n = 4'b1101; allow_single = 1'b1; tone_enable = 1'b1;
    repeat (4) @(negedge clk);
    // R1: outputs held at zero in reset despite a pressed key
    check("R1", "mute", int'(mute), 0);
    check("R1", "osc_run", int'(osc_run), 0);
    check("R1", "low_en", int'(low_en), 0);
    check("R1", "high_en", int'(high_en), 0);
    check("R1", "low_idx", int'(low_idx), 0);
    check("R1", "high_idx", int'(high_idx), 0);
    row_n = 4'hF; col_n = 4'hF; allow_single = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check_on = 1'b1;

    // R11: key seen after the third edge, not before
    row_n = 4'b1011; col_n = 4'b0111; tone_enable = 1'b1;
    @(negedge clk); check("R11", "low_en edge1", int'(low_en), 0);
    @(negedge clk); check("R11", "low_en edge2", int'(low_en), 0);
    @(negedge clk); check("R11", "low_en edge3", int'(low_en), 1);
    apply(4'hF, 4'hF, 1'b0, 1'b1, 5);

    // R3 R5 R6 R7 R8: all sixteen keys, both inhibit settings
    for (int a = 0; a < 2; a++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          apply(~(4'b1 << i), ~(4'b1 << j), a[0], 1'b1, 4);

    // R4: disable with a clean key, mute still follows
    apply(4'b1101, 4'b1011, 1'b1, 1'b0, 5);
    apply(4'b0101, 4'b1011, 1'b1, 1'b0, 5);
    // R9: column-only and row-only activity
    apply(4'hF, 4'b1110, 1'b1, 1'b1, 5);
    apply(4'b0111, 4'hF, 1'b1, 1'b1, 5);
    // R6 R7 R8 with both inhibit settings
    for (int a = 0; a < 2; a++) begin
      apply(4'b0011, 4'b1101, a[0], 1'b1, 5);
      apply(4'b1011, 4'b0110, a[0], 1'b1, 5);
      apply(4'b0000, 4'b0000, a[0], 1'b1, 5);
      apply(4'b1001, 4'b0101, a[0], 1'b1, 5);
    end
    // R2: mute with inhibit low and tones off
    apply(4'b0000, 4'hF, 1'b0, 1'b0, 5);
    apply(4'hF, 4'hF, 1'b0, 1'b1, 5);

    for (int k = 0; k < 300; k++) begin
      logic [9:0] v;
      v = 10'($urandom);
      apply(v[3:0], v[7:4], v[8], v[9] | v[1], 4);
    end
    apply(4'hF, 4'hF, 1'b0, 1'b1, 6);
    finish_run();
  end
endmodule